// File: doc/BRIEF.md
# Sixteen-Operation Integer ALU with Status Flags

This block is a purely combinational 16-bit arithmetic and logic unit for a small microcoded datapath. The first operand arrives from a register read port. The second operand is picked by a 2-bit selector from four sources: another register read port, an immediate value, the constant 0 or the constant 1. Because the unit carries the two constants internally, the control sequencer can increment a register or compare it against zero without any extra datapath hardware.

A 4-bit operation code chooses one of sixteen functions. These cover arithmetic, bitwise logic, shifts and rotates. Next to the 16-bit result the unit reports three flags: zero, negative and carry. Any registering of the result or the flags is left to the surrounding datapath.

Top module: `alu16_core`

## Requirements
- R1: `opnd_sel_i` picks operand B. 0 selects `regb_i`, 1 selects `imm_i`, 2 selects the constant 0 and 3 selects the constant 1.
- R2: Code 0 adds and code 1 subtracts (A minus B), both modulo 2^16. On an add, carry is the carry out of bit 15. On a subtract, carry is 1 exactly when A >= B as unsigned values, meaning no borrow occurs.
- R3: Code 2 gives the low 16 bits of A times B.
- R4: Code 3 gives the unsigned quotient A / B. When B is 0 the result is 0xFFFF.
- R5: Code 4 gives the unsigned remainder A mod B. When B is 0 the result is A.
- R6: Codes 5 to 10 give AND, OR, XOR, NAND, NOR and NOT. NOT returns the inverse of A, and operand B has no effect on it.
- R7: Code 11 is a logical left shift, code 12 a logical right shift and code 13 an arithmetic right shift. Each shifts A by B[3:0] places.
- R8: Code 14 rotates A left and code 15 rotates A right, by B[3:0] places.
- R9: The carry flag is 0 for every code from 2 to 15.
- R10: The negative flag equals bit 15 of the result.
- R11: The zero flag is 1 exactly when all 16 result bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 16 | Operand A, from a register read port |
| regb_i | input | 16 | Register candidate for operand B |
| imm_i | input | 16 | Immediate candidate for operand B |
| opnd_sel_i | input | 2 | Operand B source select |
| op_i | input | 4 | Operation code |
| result_o | output | 16 | Operation result |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Result bit 15 |
| carry_o | output | 1 | Add carry-out, or subtract no-borrow |

## Verification
The cases that are hardest to reach from the ports are divide and remainder by zero, and the unsigned-equal boundary of subtract, where the carry flag must be set while the result is zero. Uniform random operands almost never produce these. The bench therefore steers them directly. It selects the constant-0 source for a zero divisor, and it uses register B equal to A for the equal-operand subtract. Random operations use a bias that sometimes drives B to zero or to small shift counts. Rotate by zero and arithmetic shift of a negative value by the full 15 places are driven as directed cases.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
    typedef enum logic [3:0] {
        OP_ADD = 4'd0,  OP_SUB = 4'd1,  OP_MUL = 4'd2,  OP_DIV = 4'd3,
        OP_REM = 4'd4,  OP_AND = 4'd5,  OP_OR  = 4'd6,  OP_XOR = 4'd7,
        OP_NAND = 4'd8, OP_NOR = 4'd9,  OP_NOT = 4'd10, OP_SHL = 4'd11,
        OP_SHR = 4'd12, OP_SAR = 4'd13, OP_ROL = 4'd14, OP_ROR = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        SRC_REG = 2'd0, SRC_IMM = 2'd1, SRC_ZERO = 2'd2, SRC_ONE = 2'd3
    } opnd_src_e;

    // Codes at or below this value are served by the arithmetic unit
    localparam logic [3:0] LAST_ARITH_OP = 4'd4;

    function automatic logic is_addsub(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction
endpackage

// File: rtl/alu16_opnd_mux.sv
module alu16_opnd_mux
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] regb,
    input  logic [W-1:0] imm,
    input  opnd_src_e    sel,
    output logic [W-1:0] opb
);
    always_comb begin
        unique case (sel)
            SRC_REG:  opb = regb;
            SRC_IMM:  opb = imm;
            SRC_ZERO: opb = '0;
            default:  opb = W'(1);
        endcase
    end
endmodule

// File: rtl/alu16_arith.sv
module alu16_arith
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] res,
    output logic         cy_raw
);
    logic [W:0]   sum_ext;
    logic         b_is_zero;

    assign sum_ext   = {1'b0, a} + {1'b0, b};
    assign b_is_zero = (b == '0);

    always_comb begin
        res    = '0;
        cy_raw = 1'b0;
        unique case (op)
            OP_ADD: begin
                res    = sum_ext[W-1:0];
                cy_raw = sum_ext[W];
            end
            OP_SUB: begin
                res    = a - b;
                cy_raw = (a >= b);
            end
            OP_MUL: res = a * b;
            OP_DIV: res = b_is_zero ? '1 : (a / b);
            OP_REM: res = b_is_zero ? a  : (a % b);
            default: begin
                res    = '0;
                cy_raw = 1'b0;
            end
        endcase
    end

    // R2: subtract carry must agree with the wrapped difference
    always_comb begin
        if (op == OP_SUB)
            assert_sub_noborrow_R2: assert (cy_raw == ((res + b) == a && a >= res))
                else $error("R2 subtract carry mismatch");
    end
endmodule

// File: rtl/alu16_bitops.sv
module alu16_bitops
    import alu16_pkg::*;
#(
    parameter int W    = 16,
    parameter int SH_W = $clog2(W)
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [SH_W-1:0] shamt,
    input  alu_op_e         op,
    output logic [W-1:0]    res
);
    logic [W-1:0] rol_v, ror_v;

    assign rol_v = (a << shamt) | (a >> (W - int'(shamt)));
    assign ror_v = (a >> shamt) | (a << (W - int'(shamt)));

    always_comb begin
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_NAND: res = ~(a & b);
            OP_NOR:  res = ~(a | b);
            OP_NOT:  res = ~a;
            OP_SHL:  res = a << shamt;
            OP_SHR:  res = a >> shamt;
            OP_SAR:  res = W'($signed(a) >>> shamt);
            OP_ROL:  res = rol_v;
            OP_ROR:  res = ror_v;
            default: res = '0;
        endcase
    end

    // R8: a rotate keeps the population count of operand A
    always_comb begin
        if (op == OP_ROL || op == OP_ROR)
            assert_rot_popcount_R8: assert ($countones(res) == $countones(a))
                else $error("R8 rotate lost bits");
    end
endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] res,
    input  alu_op_e      op,
    input  logic         cy_raw,
    output logic         zero,
    output logic         neg,
    output logic         carry
);
    assign zero  = ~(|res);
    assign neg   = res[W-1];
    assign carry = is_addsub(op) & cy_raw;
endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [15:0] opa_i,
    input  logic [15:0] regb_i,
    input  logic [15:0] imm_i,
    input  logic [1:0]  opnd_sel_i,
    input  logic [3:0]  op_i,
    output logic [15:0] result_o,
    output logic        zero_o,
    output logic        neg_o,
    output logic        carry_o
);
    localparam int SH_W = $clog2(W);

    alu_op_e      op;
    logic [W-1:0] opb, arith_res, bit_res, res;
    logic         cy_raw;

    assign op = alu_op_e'(op_i);

    alu16_opnd_mux #(.W(W)) u_mux (
        .regb(regb_i), .imm(imm_i), .sel(opnd_src_e'(opnd_sel_i)), .opb(opb)
    );

    alu16_arith #(.W(W)) u_arith (
        .a(opa_i), .b(opb), .op(op), .res(arith_res), .cy_raw(cy_raw)
    );

    alu16_bitops #(.W(W), .SH_W(SH_W)) u_bits (
        .a(opa_i), .b(opb), .shamt(opb[SH_W-1:0]), .op(op), .res(bit_res)
    );

    assign res      = (op_i <= LAST_ARITH_OP) ? arith_res : bit_res;
    assign result_o = res;

    alu16_flags #(.W(W)) u_flags (
        .res(res), .op(op), .cy_raw(cy_raw),
        .zero(zero_o), .neg(neg_o), .carry(carry_o)
    );

    // Cross-unit checks on the port-level behaviour
    always_comb begin
        if (opnd_sel_i == 2'd2)
            assert_const_zero_R1: assert (opb == '0) else $error("R1 constant 0 source");
        if (op == OP_DIV && opb == '0)
            assert_div_zero_R4: assert (result_o == 16'hFFFF) else $error("R4 divide by zero");
        if (op == OP_REM && opb == '0)
            assert_rem_zero_R5: assert (result_o == opa_i) else $error("R5 remainder by zero");
        if (!is_addsub(op))
            assert_carry_quiet_R9: assert (!carry_o) else $error("R9 carry outside add/sub");
        assert_zero_flag_R11: assert (zero_o == (result_o == 16'h0)) else $error("R11 zero flag");
        assert_neg_flag_R10: assert (neg_o == result_o[15]) else $error("R10 negative flag");
    end
endmodule

// File: tb/sim_alu16_core.sv
module sim_alu16_core;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [15:0] opa, regb, imm, result;
    logic [1:0]  sel;
    logic [3:0]  op;
    logic        zf, nf, cf;
    int          checks = 0, failures = 0;
    bit          done = 0;

    alu16_core u0 (
        .opa_i(opa), .regb_i(regb), .imm_i(imm), .opnd_sel_i(sel), .op_i(op),
        .result_o(result), .zero_o(zf), .neg_o(nf), .carry_o(cf)
    );

    function automatic logic [15:0] pick_b(logic [1:0] s, logic [15:0] r, logic [15:0] i);
        case (s)
            2'd0: return r;
            2'd1: return i;
            2'd2: return 16'h0000;
            default: return 16'h0001;
        endcase
    endfunction

    // Returns {carry, result}
    function automatic logic [16:0] model(logic [3:0] o, logic [15:0] a, logic [15:0] b);
        logic [15:0] r = 0;
        logic        c = 0;
        int          n = int'(b[3:0]);
        logic [31:0] p;
        case (o)
            4'd0: begin p = 32'(a) + 32'(b); r = p[15:0]; c = p[16]; end
            4'd1: begin r = 16'(int'(a) - int'(b)); c = (int'(a) >= int'(b)); end
            4'd2: begin p = 32'(a) * 32'(b); r = p[15:0]; end
            4'd3: r = (b == 0) ? 16'hFFFF : 16'(int'(a) / int'(b));
            4'd4: r = (b == 0) ? a : 16'(int'(a) % int'(b));
            4'd5: r = a & b;
            4'd6: r = a | b;
            4'd7: r = a ^ b;
            4'd8: r = ~(a & b);
            4'd9: r = ~(a | b);
            4'd10: r = ~a;
            4'd11: for (int k = 0; k < 16; k++) r[k] = (k >= n) ? a[k-n] : 1'b0;
            4'd12: for (int k = 0; k < 16; k++) r[k] = (k + n < 16) ? a[k+n] : 1'b0;
            4'd13: for (int k = 0; k < 16; k++) r[k] = (k + n < 16) ? a[k+n] : a[15];
            4'd14: for (int k = 0; k < 16; k++) r[k] = a[(k - n + 16) % 16];
            default: for (int k = 0; k < 16; k++) r[k] = a[(k + n) % 16];
        endcase
        return {c, r};
    endfunction

    function automatic string tag_of(logic [3:0] o);
        if (o <= 4'd1) return "R2";
        if (o == 4'd2) return "R3";
        if (o == 4'd3) return "R4";
        if (o == 4'd4) return "R5";
        if (o <= 4'd10) return "R6";
        if (o <= 4'd13) return "R7";
        return "R8";
    endfunction

    task automatic check_word(string req, logic [18:0] act, logic [18:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: {c,n,z,res} actual=%h expected=%h (op=%0d a=%h sel=%0d)",
                     req, act, exp, op, opa, sel);
        end
    endtask

    // Apply one stimulus, check result and all three flags half a cycle later
    task automatic run(logic [3:0] o, logic [15:0] a, logic [15:0] r, logic [15:0] i,
                       logic [1:0] s, string req);
        logic [16:0] m;
        logic [15:0] b;
        @(posedge clk);
        op = o; opa = a; regb = r; imm = i; sel = s;
        b = pick_b(s, r, i);
        m = model(o, a, b);
        @(negedge clk);
        // R9 carry zero outside add/sub, R10 negative = bit 15, R11 zero flag
        check_word(req, {cf, nf, zf, result},
                   {(o <= 4'd1) ? m[16] : 1'b0, m[15], (m[15:0] == 16'h0), m[15:0]});
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        opa = 0; regb = 0; imm = 0; sel = 0; op = 0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Idle state: 0 + 0 gives zero flag only (R11)
        check_word("R11", {cf, nf, zf, result}, {1'b0, 1'b0, 1'b1, 16'h0});

        run(4'd0, 16'hFFFF, 16'h0001, 16'h0, 2'd0, "R2");  // wrap to zero, carry, zero flag
        run(4'd1, 16'h1234, 16'h1234, 16'h0, 2'd0, "R2");  // equal: carry set, result 0
        run(4'd1, 16'h0003, 16'h0005, 16'h0, 2'd0, "R2");  // borrow: carry 0, negative
        run(4'd0, 16'h0041, 16'h9999, 16'h0, 2'd3, "R1");  // const 1 increment
        run(4'd1, 16'h8000, 16'h7777, 16'h0, 2'd2, "R1");  // compare with const 0
        run(4'd0, 16'h0100, 16'h5555, 16'h00FF, 2'd1, "R1"); // immediate source
        run(4'd2, 16'hFFFF, 16'hFFFF, 16'h0, 2'd0, "R3");  // low product, carry R9 quiet
        run(4'd3, 16'hBEEF, 16'h1111, 16'h0, 2'd2, "R4");  // divide by zero
        run(4'd3, 16'd100,  16'd7,    16'h0, 2'd0, "R4");
        run(4'd4, 16'hBEEF, 16'h1111, 16'h0, 2'd2, "R5");  // remainder by zero
        run(4'd4, 16'd100,  16'd7,    16'h0, 2'd0, "R5");
        run(4'd10, 16'h0F0F, 16'h1234, 16'h0, 2'd0, "R6"); // NOT ignores B
        run(4'd10, 16'h0F0F, 16'hFFFF, 16'h0, 2'd0, "R6");
        run(4'd13, 16'h8000, 16'h000F, 16'h0, 2'd0, "R7"); // full arithmetic shift
        run(4'd11, 16'h0001, 16'hFFF3, 16'h0, 2'd0, "R7"); // only B[3:0] counts
        run(4'd14, 16'hA5C3, 16'h0010, 16'h0, 2'd0, "R8"); // rotate by 0
        run(4'd15, 16'h0001, 16'h0001, 16'h0, 2'd3, "R8"); // ror 1 -> 0x8000
        run(4'd5, 16'hF0F0, 16'hFF00, 16'h0, 2'd0, "R9");  // logic op, carry quiet

        for (int t = 0; t < 4000; t++) begin
            logic [3:0]  o = 4'($urandom_range(0, 15));
            logic [15:0] a = 16'($urandom);
            logic [15:0] r = 16'($urandom);
            logic [15:0] i = 16'($urandom_range(0, 20));
            logic [1:0]  s = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 7) == 0) r = 16'h0;
            run(o, a, r, i, s, tag_of(o));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule